// File: doc/BRIEF.md
# Saturating Event Tally with Timestamp Log

This block counts pulses on an asynchronous event input and keeps a short history of when they happened. The event line is first brought into the clock domain and then edge-detected, so a pulse of any length counts once. Each counted event bumps an 8-bit tally and stores the current value of a timestamp input word in a small log. The time source itself is outside the block and only arrives as that input word.

A host reaches the block through a minimal register bus: a write strobe, an address, write data and combinational read data. The tally stops at its top value rather than wrapping. The only way back to zero is a zero write to the tally register, and that write also empties the log. A separate index register moves the log read selector. Writing zero there only points the reader at the oldest entry and changes nothing else.

Top module: `evt_tally`

## Requirements
- R1: Each qualified event raises the tally by exactly one while the tally is below 255.
- R2: After reset the tally is 0, every log valid flag is 0 and the read index is 0.
- R3: At 255 the tally holds its value on further events until a zero write clears it.
- R4: Writing 0x00 to address 0 (tally) sets the tally to 0 and clears all log valid flags. The next event is then stored in entry 0.
- R5: Writing 0 to address 1 (index) selects entry 0 for reading and leaves the tally and the log unchanged.
- R6: A high level on `evtIn` counts once, however long it is held. The tally changes on the third rising clock edge after `evtIn` rises, and not before.
- R7: Each event stores `stampIn` as sampled on the edge where the tally changes. Entries fill in order 0, 1, 2, 3, and entry i sets bit i of the valid mask at address 2.
- R8: Once all four entries are valid, each newer event overwrites entry 3 and leaves entries 0 to 2 intact.
- R9: When a zero write to the tally and an event's update fall on the same edge, the clear wins: the tally ends at 0 and no entry is marked valid.
- R10: A write of any nonzero value to the tally register is ignored, and the tally and the log keep their state.
- R11: Reads return the following. Address 0 gives the tally. Address 1 gives the index (the written value modulo 4). Address 2 gives the valid mask in bits 3:0. Address 3 gives 0. `logStamp` shows the entry chosen by the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 1 | Asynchronous event line, counted on rising edge |
| stampIn | input | 16 | Current time word captured per event |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data (combinational) |
| logStamp | output | 16 | Timestamp of the log entry selected by the index |

## Verification
Stimulus covers four event shapes: short pulses, pulses held for many cycles, a run of 260 consecutive events, and an event whose update lands on the same edge as a clear. Short and long pulses show whether edge detection or level counting is in place. The long run checks the tally against min(n,255) after every event, which separates saturation from wraparound and from an early stop. Host writes of zero versus nonzero values, sent to each of the two writable registers, separate a full clear from a pure reposition and from an ignored write. The stamps are distinct, so each read of the log shows which entry was overwritten after the log filled.

// File: rtl/evt_tally_pkg.sv
package evt_tally_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_INDEX = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_VALID = 2'd2;

  typedef struct packed {
    logic clrAll;   // zero write to the tally register
    logic bump;     // qualified event, already masked by clrAll
    logic idxLoad;  // write to the index register
  } strobe_t;
endpackage

// File: rtl/evt_tally_ctrl.sv
module evt_tally_ctrl
  import evt_tally_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtIn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   riseNow;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else if (gi == 0) syncQ[gi] <= evtIn;
        else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign riseNow = syncQ[SYNC_STAGES-1] & ~prevQ;

  always_comb begin
    strb.clrAll  = busWe && (busAddr == ADDR_COUNT) && (busWdata == '0);
    strb.idxLoad = busWe && (busAddr == ADDR_INDEX);
    strb.bump    = riseNow && !strb.clrAll;
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    riseNow |=> !riseNow); // R6
endmodule

// File: rtl/evt_tally_dp.sv
module evt_tally_dp
  import evt_tally_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STAMP_W   = 16,
  parameter int LOG_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [STAMP_W-1:0] stampIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [STAMP_W-1:0] logStamp
);
  localparam int LOG_AW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam logic [DATA_W-1:0] CNT_MAX = '1;
  localparam logic [LOG_AW-1:0] LAST_IDX = LOG_AW'(LOG_DEPTH-1);

  logic [DATA_W-1:0]    countQ;
  logic [LOG_DEPTH-1:0] validQ;
  logic [LOG_AW-1:0]    wrPtr;
  logic [LOG_AW-1:0]    rdIdx;
  logic [STAMP_W-1:0]   logMem [LOG_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      wrPtr  <= '0;
    end else if (strb.clrAll) begin
      countQ <= '0;
      wrPtr  <= '0;
    end else if (strb.bump) begin
      if (countQ != CNT_MAX) countQ <= countQ + 1'b1;
      if (wrPtr != LAST_IDX) wrPtr <= wrPtr + 1'b1;
    end
  end

  genvar ei;
  generate
    for (ei = 0; ei < LOG_DEPTH; ei++) begin : g_entry
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[ei] <= 1'b0;
          logMem[ei] <= '0;
        end else if (strb.clrAll) begin
          validQ[ei] <= 1'b0;
        end else if (strb.bump && (wrPtr == LOG_AW'(ei))) begin
          validQ[ei] <= 1'b1;
          logMem[ei] <= stampIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdIdx <= '0;
    else if (strb.idxLoad) rdIdx <= busWdata[LOG_AW-1:0];
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_COUNT: busRdata = countQ;
      ADDR_INDEX: busRdata = DATA_W'(rdIdx);
      ADDR_VALID: busRdata = DATA_W'(validQ);
      default:    busRdata = '0;
    endcase
  end

  assign logStamp = logMem[rdIdx];

  AST_INCR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bump && countQ != CNT_MAX) |=> countQ == $past(countQ) + 1'b1); // R1
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CNT_MAX && !strb.clrAll) |=> countQ == CNT_MAX); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (countQ == '0 && validQ == '0)); // R4
  AST_IDX_NO_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.idxLoad && !strb.clrAll && !strb.bump) |=> ($stable(countQ) && $stable(validQ))); // R5
  AST_LAST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (validQ[LOG_DEPTH-1] && !strb.clrAll) |=> validQ[LOG_DEPTH-1]); // R8
  AST_VALID_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ) == int'(wrPtr) + (validQ[LOG_DEPTH-1] ? 1 : 0)); // R7
endmodule

// File: rtl/evt_tally.sv
module evt_tally
  import evt_tally_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAMP_W     = 16,
  parameter int LOG_DEPTH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtIn,
  input  logic [STAMP_W-1:0] stampIn,
  input  logic               busWe,
  input  logic [1:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [STAMP_W-1:0] logStamp
);
  strobe_t strb;

  evt_tally_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .strb(strb)
  );

  evt_tally_dp #(.DATA_W(DATA_W), .STAMP_W(STAMP_W), .LOG_DEPTH(LOG_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stampIn(stampIn),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .logStamp(logStamp)
  );
endmodule

// File: tb/evt_tally_bench.sv
`timescale 1ns/1ps
module evt_tally_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtIn = 1'b0;
  logic [15:0] stampIn = '0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [15:0] logStamp;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  evt_tally u_evt_tally (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .stampIn(stampIn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .logStamp(logStamp)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    busAddr = a;
    #1 v = int'(busRdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] st, input int hold);
    @(negedge clk);
    stampIn = st;
    evtIn = 1'b1;
    repeat (hold) @(negedge clk);
    evtIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic peek(input int idx, output int v);
    wr(2'd1, 8'(idx));
    #1 v = int'(logStamp);
  endtask

  initial begin
    int v;
    int expCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    rd(2'd0, v); check("R2 tally", v, 0);
    rd(2'd2, v); check("R2 valid", v, 0);
    rd(2'd1, v); check("R2 index", v, 0);

    // R6 latency and single count
    @(negedge clk);
    stampIn = 16'h1000; evtIn = 1'b1; busAddr = 2'd0;
    @(negedge clk); @(negedge clk);
    check("R6 before third edge", int'(busRdata), 0);
    @(negedge clk);
    check("R6 R1 at third edge", int'(busRdata), 1);
    repeat (10) @(negedge clk);
    evtIn = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, v); check("R6 long level counts once", v, 1);

    // R7 fill order and valid mask
    pulse(16'h1001, 1);
    rd(2'd2, v); check("R7 mask after 2", v, 3);
    pulse(16'h1002, 2);
    pulse(16'h1003, 1);
    rd(2'd2, v); check("R7 mask after 4", v, 15);
    for (int i = 0; i < 4; i++) begin
      peek(i, v); check("R7 entry stamp", v, 16'h1000 + i);
    end

    // R8 overwrite last entry
    pulse(16'h2000, 1);
    pulse(16'h2001, 1);
    peek(3, v); check("R8 last overwritten", v, 16'h2001);
    peek(2, v); check("R8 entry2 intact", v, 16'h1002);
    rd(2'd0, v); check("R1 tally six", v, 6);

    // R5 zero index write only repositions
    wr(2'd1, 8'd0);
    #1 check("R5 selects entry0", int'(logStamp), 16'h1000);
    rd(2'd0, v); check("R5 tally kept", v, 6);
    rd(2'd2, v); check("R5 log kept", v, 15);

    // R11 index modulo and reserved read
    wr(2'd1, 8'd5);
    rd(2'd1, v); check("R11 index modulo", v, 1);
    #1 check("R11 logStamp follows index", int'(logStamp), 16'h1001);
    rd(2'd3, v); check("R11 reserved reads zero", v, 0);

    // R10 nonzero writes ignored
    wr(2'd0, 8'h55);
    wr(2'd0, 8'h01);
    rd(2'd0, v); check("R10 tally unchanged", v, 6);
    rd(2'd2, v); check("R10 log unchanged", v, 15);

    // R4 zero write clears
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R4 tally cleared", v, 0);
    rd(2'd2, v); check("R4 valid cleared", v, 0);
    pulse(16'h3000, 1);
    rd(2'd2, v); check("R4 restart entry0", v, 1);
    peek(0, v); check("R4 entry0 stamp", v, 16'h3000);

    // R9 clear wins over same-edge event
    @(negedge clk);
    stampIn = 16'h4000; evtIn = 1'b1;
    @(negedge clk); @(negedge clk);
    busWe = 1'b1; busAddr = 2'd0; busWdata = 8'h00;
    @(negedge clk);
    busWe = 1'b0;
    #1 check("R9 tally zero", int'(busRdata), 0);
    evtIn = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R9 no valid entry", v, 0);

    // R3 saturation sweep
    for (int n = 1; n <= 260; n++) begin
      pulse(16'(n), 1);
      expCnt = (n > 255) ? 255 : n;
      rd(2'd0, v);
      if (v != expCnt || n == 255 || n == 260) check("R3 R1 sweep tally", v, expCnt);
    end
    peek(3, v); check("R3 R8 last stamp", v, 260);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R3 zero after sat", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule